// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Controller

This block chooses which oscillator clocks the core after a reset or after a wake from sleep. A crystal-type primary oscillator needs time to settle. The controller runs the core from an always-ready internal oscillator while a start-up counter, clocked by the primary oscillator, counts its first cycles. When the counter expires, and after an extra lock interval when a PLL is in use, the controller hands the core over to the primary source. Software takes no part in the handover.

If the feature is disabled while a crystal mode is selected, the core is held without a clock until the counter expires. An external (non-crystal) primary source skips the count and is selected at once. A sleep request made during the warm-up phase is obeyed: the pending start-up is dropped, and the next wake starts a fresh count. The clock mux is represented by two gate-enable outputs, one in each clock domain. Each enable may rise only after the other side's enable, synchronised into its own domain, is seen low. This keeps the handover free of runt pulses.

The 3-bit internal rate select is passed on to the internal oscillator postscaler. It tracks its input while the device is awake and is frozen on entry to sleep, so the rate chosen before sleeping is the one used at the next wake.

Top module: `tss_clkctl`

## Requirements
- R1: With `feat_en`=1 and a crystal mode (`pri_mode` 01 low/standard crystal, 10 high-speed crystal, 11 high-speed crystal with PLL), `run_mode` reads 01 (internal clocking) and `clk_sel_int` is 1 within 4 internal cycles after reset release or a wake, while `pri_run` is 0.
- R2: With a crystal mode and `feat_en`=0, `run_mode` reads 11 (core clock held) and `clk_sel_int` stays 0 until the primary source takes over.
- R3: With `pri_mode`=00 (external clock) no start-up count runs: `pri_run` becomes 1 within 30 internal cycles, and `clk_sel_int` never rises.
- R4: In modes 01 and 10 the primary source is not selected before `OST_CYCLES` primary cycles have elapsed since the start. It is selected automatically (`run_mode`=10) within `OST_CYCLES`+12 primary cycles plus 20 internal cycles.
- R5: In mode 11 the count is extended by `PLL_LOCK_CYCLES` primary cycles before the handover.
- R6: `pri_run` is 1 only while `clk_sel_pri` is 1 and `clk_sel_int` is 0; `run_mode` then reads 10.
- R7: `clk_sel_int` and `clk_sel_pri` are never 1 together. At a handover, `clk_sel_pri` rises 2 to 4 primary clock edges after `clk_sel_int` falls.
- R8: A `sleep_req` while `run_mode` is 01 or 10 gives `run_mode`=00 in the next cycle, with `pri_run`=0 and `clk_sel_int`=0. `clk_sel_pri` falls soon after, and any pending start-up is abandoned.
- R9: A `sleep_req` while `run_mode` is 11 is ignored.
- R10: Every wake restarts the full start-up count from zero, even when the previous count was cut short by sleep.
- R11: `wake_evt` has no effect outside sleep. In sleep, the block stays asleep until `wake_evt` is seen, and `wake_evt` then starts the wake sequence.
- R12: `fsel_out` follows `fsel_in` one cycle later while awake. During sleep it holds the value present in the cycle the sleep request was taken.
- R13: During reset `run_mode`=00, `clk_sel_int`=0, `clk_sel_pri`=0, `pri_run`=0 and `fsel_out`=0. Reset then proceeds like a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock; the controller runs on it |
| clk_pri | input | 1 | Primary oscillator clock; the start-up counter runs on it |
| rst | input | 1 | Synchronous active-high reset (internal domain) |
| sleep_req | input | 1 | Request to enter sleep |
| wake_evt | input | 1 | Wake event |
| feat_en | input | 1 | Configuration bit enabling two-speed start-up |
| pri_mode | input | 2 | Primary source mode: 00 external, 01/10 crystal, 11 crystal with PLL |
| fsel_in | input | FSEL_W | Internal oscillator rate select |
| clk_sel_int | output | 1 | Gate enable for the internal clock to the core |
| clk_sel_pri | output | 1 | Gate enable for the primary clock to the core (primary domain) |
| pri_run | output | 1 | Status: primary oscillator is clocking the core |
| run_mode | output | 2 | 00 sleep, 01 internal, 10 primary, 11 held |
| fsel_out | output | FSEL_W | Latched rate select for the internal postscaler |

## Verification
Two events can arrive in the same cycle: a sleep request, and the synchronised expiry of the start-up counter. In the controller, sleep wins over the handover. Random abort points spread sleep requests across the whole warm-up window, and a property checks every such cycle: the next state must be sleep, never the handover. The bench then wakes the block and requires the primary source to stay deselected for a full fresh count. This catches a counter that kept its old progress, or an expiry flag still in flight, which must not trigger the handover early.

// File: rtl/tss_pkg.sv
package tss_pkg;

    typedef enum logic [1:0] {
        PM_EXTCLK   = 2'b00,
        PM_XTAL_LO  = 2'b01,
        PM_XTAL_HS  = 2'b10,
        PM_XTAL_PLL = 2'b11
    } pri_mode_e;

    typedef enum logic [1:0] {
        RM_SLEEP    = 2'b00,
        RM_INTERNAL = 2'b01,
        RM_PRIMARY  = 2'b10,
        RM_HOLD     = 2'b11
    } run_mode_e;

    typedef enum logic [2:0] {
        ST_SLEEP   = 3'd0,
        ST_WARM    = 3'd1,
        ST_STALL   = 3'd2,
        ST_HANDOFF = 3'd3,
        ST_PRIMARY = 3'd4
    } ctl_state_e;

    // Requests from the internal-clock controller to the primary-clock side
    typedef struct packed {
        logic ost_run;   // start-up counter may count
        logic pll;       // extend count by the PLL lock interval
        logic want_pri;  // controller wants the primary clock gated on
    } ctl_req_t;

    function automatic logic is_crystal(input pri_mode_e m);
        return m != PM_EXTCLK;
    endfunction

    function automatic ctl_state_e start_state(input pri_mode_e m, input logic feat);
        if (!is_crystal(m))
            return ST_HANDOFF;
        else if (feat)
            return ST_WARM;
        else
            return ST_STALL;
    endfunction

    function automatic run_mode_e mode_of(input ctl_state_e s);
        case (s)
            ST_WARM:    return RM_INTERNAL;
            ST_PRIMARY: return RM_PRIMARY;
            ST_STALL,
            ST_HANDOFF: return RM_HOLD;
            default:    return RM_SLEEP;
        endcase
    endfunction

endpackage

// File: rtl/tss_sync.sv
module tss_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tss_pri_side.sv
module tss_pri_side
    import tss_pkg::*;
#(
    parameter int OST_CYCLES      = 1024,
    parameter int PLL_LOCK_CYCLES = 512,
    parameter int SYNC_STAGES     = 2
) (
    input  logic     clk_pri,
    input  logic     rst,
    input  ctl_req_t req,
    input  logic     int_en,
    output logic     ost_done,
    output logic     pri_en
);
    localparam int LIMIT_MAX = OST_CYCLES + PLL_LOCK_CYCLES;
    localparam int CW        = $clog2(LIMIT_MAX + 1);
    localparam int BW        = $bits(ctl_req_t) + 1;

    logic          rst_p;
    logic [BW-1:0] bundle_s;
    ctl_req_t      req_s;
    logic          int_en_s;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // reset brought into the primary domain
    tss_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rst_sync (
        .clk (clk_pri),
        .rst (1'b0),
        .d   (rst),
        .q   (rst_p)
    );

    // controller requests and internal gate state brought across
    tss_sync #(.WIDTH(BW), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk (clk_pri),
        .rst (rst_p),
        .d   ({req, int_en}),
        .q   (bundle_s)
    );

    assign req_s    = ctl_req_t'(bundle_s[BW-1:1]);
    assign int_en_s = bundle_s[0];
    assign limit    = req_s.pll ? CW'(LIMIT_MAX) : CW'(OST_CYCLES);

    // start-up counter: cleared whenever counting is not requested
    always_ff @(posedge clk_pri) begin
        if (rst_p || !req_s.ost_run) begin
            cnt      <= '0;
            ost_done <= 1'b0;
        end else if (!ost_done) begin
            cnt <= cnt + CW'(1);
            if (cnt == limit - CW'(1))
                ost_done <= 1'b1;
        end
    end

    // primary gate: opens only once the internal gate is seen closed
    always_ff @(posedge clk_pri) begin
        if (rst_p) pri_en <= 1'b0;
        else       pri_en <= req_s.want_pri && !int_en_s;
    end
endmodule

// File: rtl/tss_ctl.sv
module tss_ctl
    import tss_pkg::*;
#(
    parameter int FSEL_W   = 3,
    parameter int FSEL_RST = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_req,
    input  logic              wake_evt,
    input  logic              feat_en,
    input  logic [1:0]        pri_mode,
    input  logic [FSEL_W-1:0] fsel_in,
    input  logic              ost_done_s,
    input  logic              pri_en_s,
    output ctl_state_e        state,
    output ctl_req_t          req,
    output logic              int_en,
    output logic [FSEL_W-1:0] fsel_q
);
    pri_mode_e  pm;
    ctl_state_e nxt;
    logic       wake_pend;
    logic       may_leave;

    assign pm        = pri_mode_e'(pri_mode);
    // leave sleep only after the primary side has fully wound down
    assign may_leave = (wake_pend || wake_evt) && !ost_done_s && !pri_en_s;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_SLEEP:   if (may_leave) nxt = start_state(pm, feat_en);
            ST_WARM:    if (sleep_req) nxt = ST_SLEEP;
                        else if (ost_done_s) nxt = ST_HANDOFF;
            ST_STALL:   if (ost_done_s) nxt = ST_HANDOFF;
            ST_HANDOFF: if (pri_en_s) nxt = ST_PRIMARY;
            ST_PRIMARY: if (sleep_req) nxt = ST_SLEEP;
            default:    nxt = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_SLEEP;
            wake_pend <= 1'b1;   // reset behaves as a wake
            int_en    <= 1'b0;
            req       <= '0;
            fsel_q    <= FSEL_W'(FSEL_RST);
        end else begin
            state        <= nxt;
            wake_pend    <= (state == ST_SLEEP) && (nxt == ST_SLEEP) && (wake_pend || wake_evt);
            int_en       <= (nxt == ST_WARM) && !pri_en_s;
            req.ost_run  <= (nxt == ST_WARM) || (nxt == ST_STALL);
            req.want_pri <= (nxt == ST_HANDOFF) || (nxt == ST_PRIMARY);
            if (state == ST_SLEEP && nxt != ST_SLEEP)
                req.pll <= (pm == PM_XTAL_PLL);
            if (state != ST_SLEEP)
                fsel_q <= fsel_in;
        end
    end
endmodule

// File: rtl/tss_clkctl.sv
module tss_clkctl
    import tss_pkg::*;
#(
    parameter int OST_CYCLES      = 1024,
    parameter int PLL_LOCK_CYCLES = 512,
    parameter int SYNC_STAGES     = 2,
    parameter int FSEL_W          = 3,
    parameter int FSEL_RST        = 0
) (
    input  logic              clk_int,
    input  logic              clk_pri,
    input  logic              rst,
    input  logic              sleep_req,
    input  logic              wake_evt,
    input  logic              feat_en,
    input  logic [1:0]        pri_mode,
    input  logic [FSEL_W-1:0] fsel_in,
    output logic              clk_sel_int,
    output logic              clk_sel_pri,
    output logic              pri_run,
    output logic [1:0]        run_mode,
    output logic [FSEL_W-1:0] fsel_out
);
    ctl_state_e state;
    ctl_req_t   req;
    logic       int_en;
    logic       ost_done;
    logic       pri_en;
    logic [1:0] back_s;

    tss_ctl #(.FSEL_W(FSEL_W), .FSEL_RST(FSEL_RST)) u_ctl (
        .clk        (clk_int),
        .rst        (rst),
        .sleep_req  (sleep_req),
        .wake_evt   (wake_evt),
        .feat_en    (feat_en),
        .pri_mode   (pri_mode),
        .fsel_in    (fsel_in),
        .ost_done_s (back_s[1]),
        .pri_en_s   (back_s[0]),
        .state      (state),
        .req        (req),
        .int_en     (int_en),
        .fsel_q     (fsel_out)
    );

    tss_pri_side #(
        .OST_CYCLES      (OST_CYCLES),
        .PLL_LOCK_CYCLES (PLL_LOCK_CYCLES),
        .SYNC_STAGES     (SYNC_STAGES)
    ) u_pri (
        .clk_pri  (clk_pri),
        .rst      (rst),
        .req      (req),
        .int_en   (int_en),
        .ost_done (ost_done),
        .pri_en   (pri_en)
    );

    // primary-domain results brought back to the controller
    tss_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_back_sync (
        .clk (clk_int),
        .rst (rst),
        .d   ({ost_done, pri_en}),
        .q   (back_s)
    );

    assign clk_sel_int = int_en;
    assign clk_sel_pri = pri_en;
    assign pri_run     = (state == ST_PRIMARY);
    assign run_mode    = mode_of(state);
endmodule

// File: rtl/tss_clkctl_chk.sv
module tss_clkctl_chk #(
    parameter int FSEL_W = 3
) (
    input logic              clk_int,
    input logic              rst,
    input logic              sleep_req,
    input logic              wake_evt,
    input logic              feat_en,
    input logic [1:0]        pri_mode,
    input logic              clk_sel_int,
    input logic              clk_sel_pri,
    input logic              pri_run,
    input logic [1:0]        run_mode,
    input logic [FSEL_W-1:0] fsel_out
);
    assert_feat_off_R2: assert property (@(posedge clk_int) disable iff (rst)
        (!feat_en && pri_mode != 2'b00) |-> !clk_sel_int);

    assert_ext_direct_R3: assert property (@(posedge clk_int) disable iff (rst)
        (pri_mode == 2'b00) |-> !clk_sel_int);

    assert_pri_status_R6: assert property (@(posedge clk_int) disable iff (rst)
        pri_run |-> (clk_sel_pri && !clk_sel_int && run_mode == 2'b10));

    assert_gate_excl_R7: assert property (@(posedge clk_int) disable iff (rst)
        !(clk_sel_int && clk_sel_pri));

    assert_sleep_entry_R8: assert property (@(posedge clk_int) disable iff (rst)
        (sleep_req && (run_mode == 2'b01 || run_mode == 2'b10)) |=> (run_mode == 2'b00));

    assert_sleep_quiet_R8: assert property (@(posedge clk_int) disable iff (rst)
        (run_mode == 2'b00) |-> (!clk_sel_int && !pri_run));

    assert_hold_no_sleep_R9: assert property (@(posedge clk_int) disable iff (rst)
        (sleep_req && run_mode == 2'b11) |=> (run_mode != 2'b00));

    assert_wake_ignored_R11: assert property (@(posedge clk_int) disable iff (rst)
        (wake_evt && !sleep_req && run_mode == 2'b10) |=> (run_mode == 2'b10));

    assert_fsel_frozen_R12: assert property (@(posedge clk_int) disable iff (rst)
        (run_mode == 2'b00 && $past(run_mode) == 2'b00) |-> $stable(fsel_out));

    assert_reset_state_R13: assert property (@(posedge clk_int)
        rst |=> (run_mode == 2'b00 && !clk_sel_int && !pri_run));
endmodule

bind tss_clkctl tss_clkctl_chk #(.FSEL_W(FSEL_W)) chk_i (
    .clk_int     (clk_int),
    .rst         (rst),
    .sleep_req   (sleep_req),
    .wake_evt    (wake_evt),
    .feat_en     (feat_en),
    .pri_mode    (pri_mode),
    .clk_sel_int (clk_sel_int),
    .clk_sel_pri (clk_sel_pri),
    .pri_run     (pri_run),
    .run_mode    (run_mode),
    .fsel_out    (fsel_out)
);

// File: tb/tss_clkctl_tb_top.sv
module tss_clkctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PRI_PERIOD = 6;
    localparam int OST        = 1024;
    localparam int PLL        = 512;
    localparam int FW         = 3;
    localparam int SEED       = 20240611;

    logic          clk_int = 1'b0;
    logic          clk_pri = 1'b0;
    logic          rst = 1'b1;
    logic          sleep_req = 1'b0;
    logic          wake_evt = 1'b0;
    logic          feat_en = 1'b1;
    logic [1:0]    pri_mode = 2'b01;
    logic [FW-1:0] fsel_in = '0;
    logic          clk_sel_int;
    logic          clk_sel_pri;
    logic          pri_run;
    logic [1:0]    run_mode;
    logic [FW-1:0] fsel_out;

    int checks = 0;
    int errors = 0;

    tss_clkctl #(
        .OST_CYCLES      (OST),
        .PLL_LOCK_CYCLES (PLL),
        .FSEL_W          (FW)
    ) dut_i (
        .clk_int     (clk_int),
        .clk_pri     (clk_pri),
        .rst         (rst),
        .sleep_req   (sleep_req),
        .wake_evt    (wake_evt),
        .feat_en     (feat_en),
        .pri_mode    (pri_mode),
        .fsel_in     (fsel_in),
        .clk_sel_int (clk_sel_int),
        .clk_sel_pri (clk_sel_pri),
        .pri_run     (pri_run),
        .run_mode    (run_mode),
        .fsel_out    (fsel_out)
    );

    initial forever #(CLK_PERIOD / 2) clk_int = ~clk_int;
    initial forever #(PRI_PERIOD / 2) clk_pri = ~clk_pri;

    // handover and exclusivity monitors (R7)
    int since_fall = -1;
    int last_ho    = -1;
    int excl_bad   = 0;

    always @(negedge clk_sel_int) since_fall = 0;
    always @(posedge clk_pri) begin
        if (run_mode == 2'b00) since_fall = -1;
        else if (since_fall >= 0) since_fall++;
    end
    always @(posedge clk_sel_pri) begin
        if (since_fall >= 0) last_ho = since_fall;
        since_fall = -1;
    end
    always @(clk_sel_int or clk_sel_pri) if (clk_sel_int && clk_sel_pri) excl_bad++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk_int);
    endtask

    function automatic int exp_start_rm(input int mode, input bit feat);
        if (mode == 0) return 3;
        return feat ? 1 : 3;
    endfunction

    function automatic int exp_limit(input int mode);
        return (mode == 3) ? OST + PLL : OST;
    endfunction

    task automatic wait_awake(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (run_mode != 2'b00) begin
                ok = 1'b1;
                break;
            end
            tick(1);
        end
    endtask

    task automatic enter_sleep();
        logic [FW-1:0] a;
        a = FW'($urandom);
        fsel_in   = a;
        sleep_req = 1'b1;
        tick(1);
        sleep_req = 1'b0;
        chk(run_mode == 2'b00, "R8 sleep taken next cycle", run_mode, 0);
        chk(pri_run == 1'b0, "R8 status cleared on sleep", pri_run, 0);
        fsel_in = ~a;
        tick(6);
        chk(fsel_out == a, "R12 rate select frozen in sleep", fsel_out, a);
        chk(run_mode == 2'b00, "R11 stays asleep without wake", run_mode, 0);
        chk(clk_sel_pri == 1'b0, "R8 primary gate released", clk_sel_pri, 0);
    endtask

    task automatic episode(input int mode, input bit feat, input bit use_reset, input bit abort);
        bit ok;
        int lim, lo;
        last_ho = -1;
        if (use_reset) begin
            rst = 1'b1;
            pri_mode = 2'(mode);
            feat_en = feat;
            tick(8);
            chk(run_mode == 2'b00 && !clk_sel_int && !pri_run && fsel_out == '0,
                "R13 reset state", run_mode, 0);
            rst = 1'b0;
        end else begin
            if (run_mode != 2'b00) enter_sleep();
            pri_mode = 2'(mode);
            feat_en  = feat;
            tick(2);
            wake_evt = 1'b1;
            tick(1);
            wake_evt = 1'b0;
        end
        wait_awake(ok);
        chk(ok, "R11 wake leaves sleep", run_mode, exp_start_rm(mode, feat));
        if (!use_reset) begin
            tick(3);
            chk(fsel_out == fsel_in, "R12 rate select tracks when awake", fsel_out, fsel_in);
        end
        if (mode == 0) begin
            bit saw_int;
            saw_int = 1'b0;
            for (int i = 0; i < 30 && !pri_run; i++) begin
                if (clk_sel_int) saw_int = 1'b1;
                tick(1);
            end
            chk(pri_run == 1'b1, "R3 external source selected directly", pri_run, 1);
            chk(!saw_int, "R3 internal never gated on", saw_int, 0);
            return;
        end
        chk(run_mode == 2'(exp_start_rm(mode, feat)), feat ? "R1 internal run mode" : "R2 held mode",
            run_mode, exp_start_rm(mode, feat));
        chk(clk_sel_int == feat, feat ? "R1 internal gate on" : "R2 internal gate off", clk_sel_int, feat);
        if (!feat) begin
            sleep_req = 1'b1;
            tick(1);
            sleep_req = 1'b0;
            chk(run_mode == 2'b11, "R9 sleep ignored while held", run_mode, 3);
        end
        if (abort && feat) begin
            tick(20 + int'($urandom % 250));
            chk(run_mode == 2'b01 && !pri_run, "R1 still internal mid-count", run_mode, 1);
            sleep_req = 1'b1;
            tick(1);
            sleep_req = 1'b0;
            chk(run_mode == 2'b00 && !clk_sel_int, "R8 start-up abandoned", run_mode, 0);
            tick(5);
            wake_evt = 1'b1;
            tick(1);
            wake_evt = 1'b0;
            wait_awake(ok);
            chk(ok && run_mode == 2'b01, "R10 rewake into internal", run_mode, 1);
        end
        lim = exp_limit(mode);
        lo  = (lim * PRI_PERIOD) / CLK_PERIOD - 3;
        tick(lo);
        chk(pri_run == 1'b0 && run_mode == 2'(exp_start_rm(mode, feat)),
            (mode == 3) ? "R5 PLL interval still pending" : "R10 R4 full count not yet over",
            run_mode, exp_start_rm(mode, feat));
        tick((16 * PRI_PERIOD) / CLK_PERIOD + 24);
        chk(pri_run == 1'b1 && run_mode == 2'b10,
            (mode == 3) ? "R5 primary after PLL lock" : "R4 automatic switch to primary", run_mode, 2);
        chk(clk_sel_pri && !clk_sel_int, "R6 primary gate matches status", clk_sel_pri, 1);
        if (feat)
            chk(last_ho >= 2 && last_ho <= 4, "R7 handover primary edges", last_ho, 3);
        wake_evt = 1'b1;
        tick(1);
        wake_evt = 1'b0;
        tick(3);
        chk(run_mode == 2'b10, "R11 wake ignored when running", run_mode, 2);
    endtask

    initial begin
        int unsigned s;
        s = $urandom(SEED);
        tick(2);
        chk(run_mode == 2'b00 && !clk_sel_int && !clk_sel_pri && !pri_run, "R13 state in reset", run_mode, 0);
        episode(1, 1'b1, 1'b1, 1'b0);
        episode(2, 1'b0, 1'b0, 1'b0);
        episode(3, 1'b1, 1'b0, 1'b0);
        episode(0, 1'b1, 1'b0, 1'b0);
        episode(3, 1'b0, 1'b1, 1'b0);
        episode(1, 1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 10; k++) begin
            int  m;
            bit  f;
            m = int'($urandom_range(3, 0));
            f = 1'($urandom);
            episode(m, f, (k % 4) == 3, 1'($urandom));
        end
        chk(excl_bad == 0, "R7 gates never both on", excl_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog R4 actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule